// File: doc/BRIEF.md
# Vertical Sync Delay and Active-Line Window

This block sits behind the sync separator of an interlaced video input. It takes the raw vertical sync, the raw horizontal sync and a field identifier, and it produces an internal vertical sync. Both edges of the internal sync are moved later by a programmable number of 32-clock units. After the falling edge of the internal sync, the block counts horizontal sync pulses to find where the stored part of each field begins. It then raises an active-line flag for a programmed number of lines. Along with the flag it gives a line index and a one-cycle strobe at the first stored line.

Three settings drive the block: a sync delay, a count of skipped lines and a count of active lines. Each is copied into a shadow register at every internal falling edge, so a write made during a field takes effect at the next field. The delay shadow comes out of reset at 58 units, which gives 1856 clocks. The second field of a frame waits one more horizontal sync than the first. With 625 lines per frame, this puts the two starting lines 313 lines apart.

Top module: `vsync_window`

## Requirements
- R1: After reset, `vsync_int` is 1, `line_active` is 0, `win_start` is 0 and `line_idx` is 0. The delay shadow holds 58 units, so the first internal falling edge uses 58*32 clocks.
- R2: Let E be the rising clock edge that first samples a new level on `vs_in`, and N the delay shadow times 32. `vsync_int` takes that level just after edge E+N+3. This holds for both the falling and the rising direction.
- R3: At each internal falling edge, the delay shadow loads `cfg_delay`. Every later delay uses that value until the next internal falling edge.
- R4: A new falling edge on `vs_in` while a fall delay is running restarts the delay from that edge. No internal falling edge is produced for the earlier edge.
- R5: The internal falling edge clears the horizontal sync count. Each later falling edge of `hs_in` adds one to it. The window opens on count `cfg_skip`+3 when `field_in` was 0, and on count `cfg_skip`+4 when it was 1. `field_in` is the value sampled at that internal edge.
- R6: A horizontal sync edge changes the outputs just after the second rising clock edge following the edge that first samples `hs_in` low. When the window opens, `win_start` is 1 for exactly one cycle and `line_idx` is 0.
- R7: While the window is open, each horizontal sync adds one to `line_idx`. The window closes on the horizontal sync with index `cfg_lines` counted from the opening one, so it stays open for exactly `cfg_lines` lines. `line_idx` then returns to 0.
- R8: A `cfg_lines` value of 0 never opens the window, and `win_start` stays 0 for that field.
- R9: An internal falling edge closes an open window in the same cycle. A horizontal sync edge detected in that cycle is not counted.
- R10: `cfg_skip`, `cfg_lines` and `field_in` are sampled only at the internal falling edge. Changes made during a field do not alter that field's window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vs_in | input | 1 | Raw vertical sync, active low |
| hs_in | input | 1 | Raw horizontal sync, active low |
| field_in | input | 1 | Field identifier: 0 first field, 1 second field |
| cfg_delay | input | 8 | Sync delay in 32-clock units |
| cfg_skip | input | 8 | Skipped-line setting |
| cfg_lines | input | 10 | Active lines per field |
| vsync_int | output | 1 | Delayed internal vertical sync, active low |
| line_active | output | 1 | Current line is inside the stored window |
| win_start | output | 1 | One-cycle strobe when the window opens |
| line_idx | output | 10 | Index of the current active line, from 0 |

## Verification
The assertions assume that every sync pulse, high or low, lasts at least a few clocks. This lets the edge detector see each transition once. They also assume that the settings reach the shadow registers only at an internal falling edge. The bench drives pulses three or more cycles wide and spaces horizontal syncs sixteen clocks apart. It raises `vs_in` only after the delayed falling edge has appeared, so the rise and fall delays never overlap. The single restart case is the exception: it deliberately places a second falling edge inside a running delay.

// File: rtl/vsync_window.sv
module vsync_window #(
  parameter int DLY_W     = 8,
  parameter int UNIT_LOG2 = 5,
  parameter int SKIP_W    = 8,
  parameter int LINES_W   = 10,
  parameter logic [DLY_W-1:0] DLY_RESET = 8'h3A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vs_in,
  input  logic               hs_in,
  input  logic               field_in,
  input  logic [DLY_W-1:0]   cfg_delay,
  input  logic [SKIP_W-1:0]  cfg_skip,
  input  logic [LINES_W-1:0] cfg_lines,
  output logic               vsync_int,
  output logic               line_active,
  output logic               win_start,
  output logic [LINES_W-1:0] line_idx
);
  localparam int CNT_W = DLY_W + UNIT_LOG2;
  localparam int HC_W  = SKIP_W + 1;

  logic [2:0] vs_sr, hs_sr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vs_sr <= '1;
      hs_sr <= '1;
    end else begin
      vs_sr <= {vs_sr[1:0], vs_in};
      hs_sr <= {hs_sr[1:0], hs_in};
    end

  wire vs_fall = vs_sr[2] & ~vs_sr[1];
  wire vs_rise = ~vs_sr[2] & vs_sr[1];
  wire hs_fall = hs_sr[2] & ~hs_sr[1];

  logic [DLY_W-1:0]   dly_q;
  logic [SKIP_W-1:0]  skip_q;
  logic [LINES_W-1:0] lines_q;
  logic               fld_q;

  logic [CNT_W-1:0] fall_cnt, rise_cnt;
  logic             fall_pend, rise_pend;
  wire  [CNT_W-1:0] span = {dly_q, {UNIT_LOG2{1'b0}}};

  wire fall_fire = fall_pend && fall_cnt == '0 && !vs_fall;
  wire rise_fire = rise_pend && rise_cnt == '0 && !vs_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fall_cnt  <= '0;
      fall_pend <= 1'b0;
    end else if (vs_fall) begin
      fall_cnt  <= span;
      fall_pend <= 1'b1;
    end else if (fall_pend) begin
      if (fall_cnt == '0) fall_pend <= 1'b0;
      else                fall_cnt  <= fall_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_cnt  <= '0;
      rise_pend <= 1'b0;
    end else if (vs_rise) begin
      rise_cnt  <= span;
      rise_pend <= 1'b1;
    end else if (rise_pend) begin
      if (rise_cnt == '0) rise_pend <= 1'b0;
      else                rise_cnt  <= rise_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         vsync_int <= 1'b1;
    else if (fall_fire) vsync_int <= 1'b0;
    else if (rise_fire) vsync_int <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dly_q   <= DLY_RESET;
      skip_q  <= '0;
      lines_q <= '0;
      fld_q   <= 1'b0;
    end else if (fall_fire) begin
      dly_q   <= cfg_delay;
      skip_q  <= cfg_skip;
      lines_q <= cfg_lines;
      fld_q   <= field_in;
    end

  logic [HC_W-1:0] hcount;
  logic            armed;
  wire  [HC_W-1:0] hcount_nx = hcount + 1'b1;
  wire  [HC_W-1:0] target    = HC_W'(skip_q) + (fld_q ? HC_W'(4) : HC_W'(3));
  wire             last_line = line_idx == LINES_W'(lines_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcount      <= '0;
      armed       <= 1'b0;
      line_active <= 1'b0;
      line_idx    <= '0;
      win_start   <= 1'b0;
    end else begin
      win_start <= 1'b0;
      if (fall_fire) begin
        hcount      <= '0;
        armed       <= 1'b1;
        line_active <= 1'b0;
        line_idx    <= '0;
      end else if (hs_fall) begin
        if (armed) begin
          hcount <= hcount_nx;
          if (hcount_nx == target) begin
            armed <= 1'b0;
            if (lines_q != '0) begin
              line_active <= 1'b1;
              win_start   <= 1'b1;
              line_idx    <= '0;
            end
          end
        end else if (line_active) begin
          if (last_line) begin
            line_active <= 1'b0;
            line_idx    <= '0;
          end else begin
            line_idx <= line_idx + 1'b1;
          end
        end
      end
    end
endmodule

// File: rtl/vsync_window_chk.sv
module vsync_window_chk #(
  parameter int LINES_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vsync_int,
  input logic               line_active,
  input logic               win_start,
  input logic [LINES_W-1:0] line_idx,
  input logic [LINES_W-1:0] lines_q
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> !win_start); // R6

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |-> (line_active && line_idx == '0)); // R6

  AST_OPEN_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_active) |-> win_start); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && $past(line_active)) |->
      (line_idx == $past(line_idx) || line_idx == $past(line_idx) + 1'b1)); // R7

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |-> line_idx < lines_q); // R7

  AST_ZERO_LINES_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (lines_q == '0) |-> !line_active); // R8

  AST_VFALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_int) |-> !line_active); // R9
endmodule

bind vsync_window vsync_window_chk #(.LINES_W(LINES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync_int(vsync_int), .line_active(line_active),
  .win_start(win_start), .line_idx(line_idx), .lines_q(lines_q)
);

// File: tb/test_vsync_window.sv
`timescale 1ns/1ps
module test_vsync_window;
  logic clk = 1'b0, rst_n = 1'b0;
  logic vs_in = 1'b1, hs_in = 1'b1, field_in = 1'b0;
  logic [7:0] cfg_delay = 8'd0, cfg_skip = 8'd0;
  logic [9:0] cfg_lines = 10'd0;
  logic vsync_int, line_active, win_start;
  logic [9:0] line_idx;

  vsync_window i_vsync_window (
    .clk(clk), .rst_n(rst_n), .vs_in(vs_in), .hs_in(hs_in), .field_in(field_in),
    .cfg_delay(cfg_delay), .cfg_skip(cfg_skip), .cfg_lines(cfg_lines),
    .vsync_int(vsync_int), .line_active(line_active), .win_start(win_start),
    .line_idx(line_idx)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { int kind; int at; string req; } ev_t;
  ev_t exp_q[$];
  localparam int K_VFALL = 0, K_VRISE = 1, K_START = 2, K_END = 3;

  int  model_dly = 58;
  bit  win_open  = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int at, input string req);
    ev_t e;
    e.kind = kind; e.at = at; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: observed events are matched in order against the queue
  bit mon_on = 1'b0;
  logic p_vs = 1'b1, p_act = 1'b0;
  task automatic note_ev(input int kind);
    ev_t e;
    if (exp_q.size() == 0) chk("R2", "unexpected event kind", kind, -1);
    else begin
      e = exp_q.pop_front();
      chk(e.req, "event kind", kind, e.kind);
      chk(e.req, "event cycle", cyc, e.at);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (vsync_int !== p_vs) note_ev(vsync_int ? K_VRISE : K_VFALL);
    if (win_start === 1'b1) note_ev(K_START);
    if (p_act === 1'b1 && line_active === 1'b0) note_ev(K_END);
    p_vs  = vsync_int;
    p_act = line_active;
  end

  // One field: optional restart (R4), vertical sync pulse, then horizontal syncs
  task automatic run_field(input bit fb, input int dly, input int skip, input int lines,
                           input int nhs, input bit mid_change, input bit restart,
                           input string vreq);
    int e, tgt, old;
    cfg_delay = 8'(dly); cfg_skip = 8'(skip); cfg_lines = 10'(lines); field_in = fb;
    old = model_dly;
    if (restart) begin
      e = cyc; vs_in = 1'b0;
      step(5); vs_in = 1'b1;
      step(5); vs_in = 1'b0;
      step(e + 4 + 32 * old - cyc);
      chk("R4", "no internal edge at first expiry", vsync_int, 1);
    end else begin
      vs_in = 1'b0;
    end
    e = (restart) ? (cyc - (4 + 32 * old) + 10 + 0) : cyc;
    if (restart) e = cyc - (32 * old + 4) + 10;
    push(K_VFALL, e + 4 + 32 * old, vreq);
    if (win_open) push(K_END, e + 4 + 32 * old, "R9");
    win_open = 1'b0;
    model_dly = dly;
    step(e + 4 + 32 * old - cyc + 6);
    if (mid_change) begin // R10: late writes must not alter this field
      cfg_skip = 8'(skip + 5); cfg_lines = 10'(lines + 1);
      field_in = ~fb; cfg_delay = 8'(dly + 3);
    end
    vs_in = 1'b1;
    push(K_VRISE, cyc + 4 + 32 * model_dly, "R3");
    step(32 * model_dly + 8);
    tgt = skip + 3 + fb;
    for (int i = 1; i <= nhs; i++) begin
      int ei;
      ei = cyc;
      hs_in = 1'b0;
      if (lines > 0 && i == tgt) begin push(K_START, ei + 3, "R5"); win_open = 1'b1; end
      if (lines > 0 && i == tgt + lines) begin push(K_END, ei + 3, "R7"); win_open = 1'b0; end
      step(3);
      hs_in = 1'b1;
      if (lines > 0 && i >= tgt && i < tgt + lines) begin
        chk("R7", "line_active inside window", line_active, 1);
        chk("R7", "line_idx", line_idx, i - tgt);
      end else begin
        chk(lines == 0 ? "R8" : "R5", "line_active outside window", line_active, 0);
      end
      step(13);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1", "vsync_int after reset", vsync_int, 1);
    chk("R1", "line_active after reset", line_active, 0);
    chk("R1", "win_start after reset", win_start, 0);
    chk("R1", "line_idx after reset", line_idx, 0);
    mon_on = 1'b1;
    // R1: first delay uses the reset shadow of 58 units
    run_field(1'b0, 1, 2, 3, 10, 1'b0, 1'b0, "R1");
    // R2/R10: second field, one unit delay, writes changed mid-field
    run_field(1'b1, 2, 2, 3, 10, 1'b1, 1'b0, "R2");
    // R8: zero active lines
    run_field(1'b0, 1, 0, 0, 6, 1'b0, 1'b0, "R3");
    // window left open at the end of the field
    run_field(1'b1, 1, 0, 5, 6, 1'b0, 1'b0, "R2");
    // R4 restart, and R9 closing of the open window
    run_field(1'b0, 1, 1, 2, 7, 1'b0, 1'b1, "R4");
    step(20);
    chk("R2", "expected events left over", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule